// File: doc/BRIEF.md
# Edge-Counting All-Digital Phase-Locked Loop

This block locks a square-wave clock made inside the chip to an external reference square wave, using only logic clocked by the system clock. A small detector turns each rising edge of the synchronised reference into an "up" step and each rising edge of the generated clock into a "down" step. A saturating up/down counter sums these steps and acts as the loop filter. The counter value is the frequency word of a phase-accumulator oscillator, whose top bit is the generated clock.

The counter starts at a nominal word supplied on an input. That word sets the oscillator's centre frequency, which is nominal / 2^ACC_W cycles per system clock. When the reference runs faster than the generated clock, up steps outnumber down steps and the frequency word rises. When it runs slower, the word falls. Because the counter stops at programmable lower and upper limits instead of wrapping, a long one-sided error cannot throw the loop into the opposite extreme.

A lock monitor watches how much the frequency word moves between consecutive reference edges. It reports lock once a programmable number of those edges in a row have each seen a change of at most one count.

Top module: `edge_count_adpll`

## Requirements
- R1: While rst_n is low, ctrl_word_o is 0, dco_clk_o is 0 and locked_o is 0. At the first clock edge after release, the counter loads nominal_word.
- R2: ref_in passes through a two-flop synchroniser. If ref_in is sampled high at clock edge k after being sampled low at edge k-1, the counter takes one up step at edge k+2.
- R3: Each rising edge of the accumulator MSB (0 in one cycle, 1 in the next) gives one down step at the following clock edge. Each up step adds one to the counter and each down step subtracts one. Without a step, the counter holds.
- R4: The counter saturates. An up step at CNT_HI leaves it at CNT_HI, and a down step at CNT_LO leaves it at CNT_LO. It never leaves [CNT_LO, CNT_HI] when nominal_word lies in that range.
- R5: At every clock edge the accumulator adds the counter value, zero-extended, modulo 2^ACC_W. The accumulator resets to 0, and dco_clk_o is its MSB.
- R6: An up step and a down step that fall on the same clock edge cancel, and the counter holds.
- R7: At each reference up step, the lock monitor compares the counter with its value at the previous reference step; the first reference step compares against nominal_word. A difference of at most one adds one to a run count, which saturates at 2^RUN_W-1; a larger difference clears the run count. locked_o is high while the run count is at least lock_edges, with lock_edges at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ref_in | input | 1 | Reference square wave, asynchronous |
| nominal_word | input | CNT_W | Centre frequency word loaded after reset |
| lock_edges | input | RUN_W | Number of quiet reference edges needed for lock |
| dco_clk_o | output | 1 | Generated square-wave clock (accumulator MSB) |
| ctrl_word_o | output | CNT_W | Current counter / frequency word |
| locked_o | output | 1 | Lock indication |

## Verification
The bench builds the block with a 6-bit counter limited to [3, 60], a 7-bit accumulator and a 3-bit run count. With a nominal word of 16, the generated clock has a period of eight system clocks, so a reference with matching period locks within a few hundred cycles. A reference held low drives the word down to the lower limit, and a reference toggling every cycle drives it up to the upper limit. A sweep of reference half-periods from two to nine cycles produces coinciding up and down steps and lock that is gained and then lost. An arithmetic model of counter, accumulator and run count, stepped every cycle, supplies the expected word, clock and lock flag for each of these cases.

// File: rtl/adpll_pkg.sv
package adpll_pkg;
  typedef struct packed {
    logic up;
    logic dn;
  } step_t;
endpackage

// File: rtl/adpll_edge_det.sv
module adpll_edge_det #(
  parameter int SYNC_N = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ref_in,
  input  logic                dco_msb,
  output adpll_pkg::step_t    step_o
);
  localparam int HIST = SYNC_N;

  logic [HIST:0] sync_q, sync_d;
  logic          msb_q, msb_d;

  always_comb begin
    sync_d = {sync_q[HIST-1:0], ref_in};
    msb_d  = dco_msb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      msb_q  <= 1'b0;
    end else begin
      sync_q <= sync_d;
      msb_q  <= msb_d;
    end
  end

  always_comb begin
    step_o.up = sync_q[HIST-1] & ~sync_q[HIST];
    step_o.dn = dco_msb & ~msb_q;
  end
endmodule

// File: rtl/adpll_loop_cnt.sv
module adpll_loop_cnt #(
  parameter int CNT_W  = 8,
  parameter int CNT_LO = 4,
  parameter int CNT_HI = 250
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CNT_W-1:0]    nominal_word,
  input  adpll_pkg::step_t    step_i,
  output logic [CNT_W-1:0]    cnt_o,
  output logic                load_o
);
  localparam logic [CNT_W-1:0] LO_V = CNT_W'(CNT_LO);
  localparam logic [CNT_W-1:0] HI_V = CNT_W'(CNT_HI);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             load_q, load_d;

  always_comb begin
    cnt_d  = cnt_q;
    load_d = 1'b0;
    if (load_q) begin
      cnt_d = nominal_word;
    end else begin
      unique case ({step_i.up, step_i.dn})
        2'b10:   cnt_d = (cnt_q >= HI_V) ? cnt_q : cnt_q + CNT_W'(1);
        2'b01:   cnt_d = (cnt_q <= LO_V) ? cnt_q : cnt_q - CNT_W'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      load_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      load_q <= load_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign load_o = load_q;
endmodule

// File: rtl/adpll_dco.sv
module adpll_dco #(
  parameter int CNT_W = 8,
  parameter int ACC_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  freq_word,
  output logic [ACC_W-1:0]  acc_o,
  output logic              msb_o
);
  logic [ACC_W-1:0] acc_q, acc_d;

  always_comb acc_d = acc_q + ACC_W'(freq_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc_o = acc_q;
  assign msb_o = acc_q[ACC_W-1];
endmodule

// File: rtl/adpll_lock_mon.sv
module adpll_lock_mon #(
  parameter int CNT_W = 8,
  parameter int RUN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              ref_step_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  nominal_word,
  input  logic [RUN_W-1:0]  lock_edges,
  output logic              locked_o
);
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic [CNT_W-1:0] snap_q, snap_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             quiet;

  always_comb begin
    quiet = (cnt_i == snap_q) ||
            (cnt_i == snap_q + CNT_W'(1)) ||
            (snap_q == cnt_i + CNT_W'(1));
    snap_d = snap_q;
    run_d  = run_q;
    if (load_i) begin
      snap_d = nominal_word;
      run_d  = '0;
    end else if (ref_step_i) begin
      snap_d = cnt_i;
      if (quiet) run_d = (run_q == RUN_MAX) ? run_q : run_q + RUN_W'(1);
      else       run_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      run_q  <= '0;
    end else begin
      snap_q <= snap_d;
      run_q  <= run_d;
    end
  end

  assign locked_o = (run_q >= lock_edges);
endmodule

// File: rtl/edge_count_adpll.sv
module edge_count_adpll #(
  parameter int CNT_W  = 8,
  parameter int ACC_W  = 12,
  parameter int CNT_LO = 4,
  parameter int CNT_HI = 250,
  parameter int RUN_W  = 4,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_in,
  input  logic [CNT_W-1:0]  nominal_word,
  input  logic [RUN_W-1:0]  lock_edges,
  output logic              dco_clk_o,
  output logic [CNT_W-1:0]  ctrl_word_o,
  output logic              locked_o
);
  adpll_pkg::step_t step_w;
  logic [CNT_W-1:0] cnt_w;
  logic [ACC_W-1:0] acc_w;
  logic             msb_w;
  logic             load_w;

  adpll_edge_det #(.SYNC_N(SYNC_N)) u_det (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .dco_msb(msb_w), .step_o(step_w)
  );

  adpll_loop_cnt #(.CNT_W(CNT_W), .CNT_LO(CNT_LO), .CNT_HI(CNT_HI)) u_cnt (
    .clk(clk), .rst_n(rst_n), .nominal_word(nominal_word), .step_i(step_w),
    .cnt_o(cnt_w), .load_o(load_w)
  );

  adpll_dco #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_dco (
    .clk(clk), .rst_n(rst_n), .freq_word(cnt_w), .acc_o(acc_w), .msb_o(msb_w)
  );

  adpll_lock_mon #(.CNT_W(CNT_W), .RUN_W(RUN_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .load_i(load_w), .ref_step_i(step_w.up),
    .cnt_i(cnt_w), .nominal_word(nominal_word), .lock_edges(lock_edges),
    .locked_o(locked_o)
  );

  assign dco_clk_o   = msb_w;
  assign ctrl_word_o = cnt_w;
endmodule

// File: rtl/adpll_checker.sv
module adpll_checker #(
  parameter int CNT_W  = 8,
  parameter int ACC_W  = 12,
  parameter int CNT_LO = 4,
  parameter int CNT_HI = 250
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic             up,
  input logic             dn,
  input logic [CNT_W-1:0] ctrl,
  input logic [ACC_W-1:0] acc,
  input logic             locked
);
  // R4: word stays inside its limits once loaded
  a_r4_in_limits: assert property (@(posedge clk) disable iff (!rst_n)
    !load |-> (ctrl >= CNT_W'(CNT_LO) && ctrl <= CNT_W'(CNT_HI)));

  // R3: word moves by at most one per clock
  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (ctrl == $past(ctrl) || ctrl == $past(ctrl) + CNT_W'(1) ||
               ctrl + CNT_W'(1) == $past(ctrl)));

  // R3: lone up step below the limit increments
  a_r3_up_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && up && !dn && ctrl < CNT_W'(CNT_HI)) |=> ctrl == $past(ctrl) + CNT_W'(1));

  // R6: coinciding steps cancel
  a_r6_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && up && dn) |=> $stable(ctrl));

  // R5: accumulator integrates the word
  a_r5_integrate: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> acc == ACC_W'($past(acc) + ACC_W'($past(ctrl))));

  // R7: lock only appears after a reference step
  a_r7_rise_on_ref: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(up));
endmodule

bind edge_count_adpll adpll_checker #(
  .CNT_W(CNT_W), .ACC_W(ACC_W), .CNT_LO(CNT_LO), .CNT_HI(CNT_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load_w), .up(step_w.up), .dn(step_w.dn),
  .ctrl(cnt_w), .acc(acc_w), .locked(locked_o)
);

// File: tb/edge_count_adpll_tb_top.sv
module edge_count_adpll_tb_top;
  localparam int CNT_W = 6, ACC_W = 7, CNT_LO = 3, CNT_HI = 60, RUN_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic [CNT_W-1:0] nominal_word = 6'd16;
  logic [RUN_W-1:0] lock_edges = 3'd3;
  logic dco_clk_o, locked_o;
  logic [CNT_W-1:0] ctrl_word_o;

  int total = 0, bad = 0, cancels = 0;
  bit check_en = 0;

  always #5 clk = ~clk;

  edge_count_adpll #(.CNT_W(CNT_W), .ACC_W(ACC_W), .CNT_LO(CNT_LO),
    .CNT_HI(CNT_HI), .RUN_W(RUN_W), .SYNC_N(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .nominal_word(nominal_word),
    .lock_edges(lock_edges), .dco_clk_o(dco_clk_o), .ctrl_word_o(ctrl_word_o),
    .locked_o(locked_o));

  // arithmetic model of the requirements
  bit s1, s2, s3, m_init, m_msbq;
  int m_cnt, m_acc, m_snap, m_run;
  string m_tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      s1 = 0; s2 = 0; s3 = 0; m_init = 1; m_msbq = 0;
      m_cnt = 0; m_acc = 0; m_snap = 0; m_run = 0; m_tag = "R1";
    end else begin
      bit up, dn, msb;
      int old_cnt;
      msb = (m_acc >> (ACC_W-1)) & 1;
      up = s2 && !s3;          // R2: two-flop delay plus edge detect
      dn = msb && !m_msbq;     // R3: accumulator MSB rising
      old_cnt = m_cnt;
      if (m_init) begin
        m_cnt = nominal_word; m_snap = nominal_word; m_run = 0; m_init = 0; m_tag = "R1";
      end else begin
        if (up && dn) begin m_tag = "R6"; cancels++; end
        else if (up) begin
          if (m_cnt >= CNT_HI) m_tag = "R4"; else begin m_cnt++; m_tag = "R2"; end
        end else if (dn) begin
          if (m_cnt <= CNT_LO) m_tag = "R4"; else begin m_cnt--; m_tag = "R3"; end
        end else m_tag = "R3";
        if (up) begin
          int d;
          d = old_cnt - m_snap;
          if (d >= -1 && d <= 1) m_run = (m_run == (1<<RUN_W)-1) ? m_run : m_run + 1;
          else m_run = 0;
          m_snap = old_cnt;
        end
      end
      m_acc = (m_acc + old_cnt) % (1 << ACC_W);
      m_msbq = msb;
      s3 = s2; s2 = s1; s1 = ref_in;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (check_en) begin
    chk(m_tag, ctrl_word_o, m_cnt);
    chk("R5", dco_clk_o, (m_acc >> (ACC_W-1)) & 1);
    chk("R7", locked_o, (m_run >= lock_edges) ? 1 : 0);
  end

  task automatic do_reset();
    check_en = 0;
    ref_in = 0;
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1", ctrl_word_o, 0);
    chk("R1", dco_clk_o, 0);
    chk("R1", locked_o, 0);
    rst_n = 1;
    @(negedge clk);
    check_en = 1;
    @(negedge clk);
    chk("R1", ctrl_word_o, nominal_word);
  endtask

  // half = 0 holds ref low; otherwise toggles every half cycles
  task automatic drive(input int half, input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      ref_in = (half == 0) ? 1'b0 : (((c / half) % 2) == 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    drive(0, 400);
    chk("R4", ctrl_word_o, CNT_LO);     // R4 lower limit
    do_reset();
    drive(1, 600);
    chk("R4", ctrl_word_o, CNT_HI);     // R4 upper limit
    do_reset();
    drive(4, 400);
    chk("R7", locked_o, 1);             // R7 matched frequency locks
    for (int h = 2; h <= 9; h++) begin
      do_reset();
      drive(h, 300);
    end
    nominal_word = 6'd40;
    do_reset();
    drive(3, 500);
    $display("info: coinciding steps seen=%0d", cancels);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule